// File: doc/BRIEF.md
# Hold-Current PWM Generator

This block turns the static on/off drive requests for a group of half-bridge outputs into requests that can be chopped by a slow pulse-width modulation. Chopping lowers the average drive of a load to a hold level once it has been pulled in. A prescaler divides the system clock down to a step rate. A phase counter then counts a fixed number of steps per PWM period, so the nominal period rate is 100 Hz when the prescaler ratio is set to match the clock. Each period starts in its on part. A two-bit code picks one of four fixed on fractions of the period.

A per-bridge mask selects the bridges that are chopped. A masked bridge is driven on only while its static request is on and the PWM is in its on part. An unmasked bridge follows its static request. The duty code and the mask are sampled only at a period boundary, so a new setting always starts a whole period and never cuts a pulse short. The gated requests are registered. During the off part a chopped bridge receives an off request, and the cross-conduction interlock downstream still handles it.

Top module: `hold_pwm_gen`

## Requirements
- R1: While reset is asserted and after it is released, `drive_out` is all zeros during reset. The active duty code is 00 and the active mask is all zeros until the first period boundary, so during the first period after reset every bridge follows its static request.
- R2: One PWM period lasts exactly `CLK_DIV * STEPS` clock cycles. The phase counter advances by one step every `CLK_DIV` cycles and wraps from `STEPS-1` to 0. Period boundaries fall at cycle multiples of the period length, counted from reset release.
- R3: Duty codes 00, 01, 10 and 11 give on parts of 15 %, 30 %, 45 % and 60 % of the period (on while phase < code_pct*STEPS/100). The on part is at the start of each period.
- R4: A bridge whose mask bit is 0 outputs its static request, delayed by one clock cycle.
- R5: A bridge whose mask bit is 1 outputs its static request ANDed with the PWM on state, delayed by one clock cycle.
- R6: Changes to `duty_code` and `pwm_mask` take effect only at the next period boundary. A change inside a period, even one that lasts a single cycle and is then undone, does not alter the current period.
- R7: A masked bridge whose static request is off stays off for the whole period. The PWM never turns a bridge on.
- R8: Mask bits at and above `NUM_BRIDGES` (bits 7:6 by default) have no effect on any output.
- R9: `drive_out` is a register output. It changes only at a rising clock edge, one cycle after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_code | input | 2 | Duty selection: 00=15 %, 01=30 %, 10=45 %, 11=60 % |
| pwm_mask | input | MASK_W (8) | Per-bridge PWM select; bit i chops bridge i; upper bits unused |
| drive_req | input | NUM_BRIDGES (6) | Static on request per bridge |
| drive_out | output | NUM_BRIDGES (6) | Gated, registered on request per bridge |

## Verification
The hardest situation to create from the ports is a setting change that lands inside a period and must stay invisible until the boundary. The stimulus therefore changes code and mask at mid-period on every run. It also applies a one-cycle glitch to both settings and reverts it. A reference model counts cycles from reset release on its own, and it latches settings only at multiples of the period length. The period length itself is checked by timing successive rising edges of a chopped output. A one-cycle glitch reaches the output only if the design samples its settings at the wrong moment.

// File: rtl/hpwm_pkg.sv
package hpwm_pkg;

  localparam int DUTY_STEP_PCT = 15;
  localparam int PCT_FULL      = 100;

  typedef logic [1:0] duty_code_t;

  // Number of phase steps for which the PWM is on for a given code.
  function automatic int duty_threshold(input duty_code_t code, input int steps);
    return ((int'(code) + 1) * DUTY_STEP_PCT * steps) / PCT_FULL;
  endfunction

  // Largest on-threshold over all codes.
  function automatic int max_threshold(input int steps);
    return duty_threshold(2'b11, steps);
  endfunction

  // Gated request: masked bridges are ANDed with the PWM state.
  function automatic logic gate_bit(input logic req, input logic sel, input logic on);
    return sel ? (req & on) : req;
  endfunction

endpackage

// File: rtl/hpwm_prescaler.sv
module hpwm_prescaler #(
  parameter int CLK_DIV = 5000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      logic unused_pins;
      assign unused_pins = clk ^ rst_n;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end

      assign tick = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/hpwm_phase_ctr.sv
module hpwm_phase_ctr #(
  parameter int STEPS = 100,
  parameter int PW    = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [PW-1:0] phase,
  output logic          period_wrap
);

  localparam logic [PW-1:0] LAST = PW'(STEPS - 1);

  assign period_wrap = tick && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           phase <= '0;
    else if (period_wrap) phase <= '0;
    else if (tick)        phase <= phase + 1'b1;
  end

endmodule

// File: rtl/hpwm_settings.sv
module hpwm_settings
  import hpwm_pkg::*;
#(
  parameter int NUM_BRIDGES = 6,
  parameter int MASK_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   period_wrap,
  input  duty_code_t             duty_code,
  input  logic [MASK_W-1:0]      pwm_mask,
  output duty_code_t             act_code,
  output logic [NUM_BRIDGES-1:0] act_mask
);

  generate
    if (MASK_W > NUM_BRIDGES) begin : g_spare
      logic unused_mask_hi;
      assign unused_mask_hi = ^pwm_mask[MASK_W-1:NUM_BRIDGES];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= '0;
      act_mask <= '0;
    end else if (period_wrap) begin
      act_code <= duty_code;
      act_mask <= pwm_mask[NUM_BRIDGES-1:0];
    end
  end

endmodule

// File: rtl/hpwm_duty_cmp.sv
module hpwm_duty_cmp
  import hpwm_pkg::*;
#(
  parameter int STEPS = 100,
  parameter int PW    = $clog2(STEPS)
) (
  input  logic [PW-1:0] phase,
  input  duty_code_t    act_code,
  output logic          pwm_on
);

  localparam int TW = PW + 1;
  localparam logic [TW-1:0] T0 = TW'(duty_threshold(2'd0, STEPS));
  localparam logic [TW-1:0] T1 = TW'(duty_threshold(2'd1, STEPS));
  localparam logic [TW-1:0] T2 = TW'(duty_threshold(2'd2, STEPS));
  localparam logic [TW-1:0] T3 = TW'(duty_threshold(2'd3, STEPS));

  logic [TW-1:0] thr;

  always_comb begin
    unique case (act_code)
      2'd0:    thr = T0;
      2'd1:    thr = T1;
      2'd2:    thr = T2;
      default: thr = T3;
    endcase
  end

  assign pwm_on = ({1'b0, phase} < thr);

endmodule

// File: rtl/hpwm_gate.sv
module hpwm_gate
  import hpwm_pkg::*;
#(
  parameter int NUM_BRIDGES = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwm_on,
  input  logic [NUM_BRIDGES-1:0] act_mask,
  input  logic [NUM_BRIDGES-1:0] drive_req,
  output logic [NUM_BRIDGES-1:0] drive_out
);

  logic [NUM_BRIDGES-1:0] gated;

  generate
    for (genvar i = 0; i < NUM_BRIDGES; i++) begin : g_br
      assign gated[i] = gate_bit(drive_req[i], act_mask[i], pwm_on);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_out <= '0;
    else        drive_out <= gated;
  end

endmodule

// File: rtl/hold_pwm_gen.sv
module hold_pwm_gen
  import hpwm_pkg::*;
#(
  parameter int CLK_DIV     = 5000,
  parameter int STEPS       = 100,
  parameter int NUM_BRIDGES = 6,
  parameter int MASK_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             duty_code,
  input  logic [MASK_W-1:0]      pwm_mask,
  input  logic [NUM_BRIDGES-1:0] drive_req,
  output logic [NUM_BRIDGES-1:0] drive_out
);

  localparam int PW = $clog2(STEPS);

  logic                   tick;
  logic [PW-1:0]          phase;
  logic                   period_wrap;
  duty_code_t             act_code;
  logic [NUM_BRIDGES-1:0] act_mask;
  logic                   pwm_on;

  hpwm_prescaler #(.CLK_DIV(CLK_DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  hpwm_phase_ctr #(.STEPS(STEPS), .PW(PW)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .phase       (phase),
    .period_wrap (period_wrap)
  );

  hpwm_settings #(.NUM_BRIDGES(NUM_BRIDGES), .MASK_W(MASK_W)) u_set (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_wrap (period_wrap),
    .duty_code   (duty_code),
    .pwm_mask    (pwm_mask),
    .act_code    (act_code),
    .act_mask    (act_mask)
  );

  hpwm_duty_cmp #(.STEPS(STEPS), .PW(PW)) u_cmp (
    .phase    (phase),
    .act_code (act_code),
    .pwm_on   (pwm_on)
  );

  hpwm_gate #(.NUM_BRIDGES(NUM_BRIDGES)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_on    (pwm_on),
    .act_mask  (act_mask),
    .drive_req (drive_req),
    .drive_out (drive_out)
  );

endmodule

// File: rtl/hpwm_chk.sv
module hpwm_chk
  import hpwm_pkg::*;
#(
  parameter int STEPS       = 100,
  parameter int NUM_BRIDGES = 6,
  parameter int MASK_W      = 8,
  parameter int PW          = $clog2(STEPS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic [PW-1:0]          phase,
  input logic                   period_wrap,
  input duty_code_t             act_code,
  input logic [NUM_BRIDGES-1:0] act_mask,
  input logic                   pwm_on,
  input logic [1:0]             duty_code,
  input logic [MASK_W-1:0]      pwm_mask,
  input logic [NUM_BRIDGES-1:0] drive_req,
  input logic [NUM_BRIDGES-1:0] drive_out
);

  localparam int MAXT = max_threshold(STEPS);

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));

  // R2
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_wrap |=> (phase == '0));

  // R3
  on_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '0) |-> pwm_on);

  // R3
  off_past_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(phase) >= MAXT) |-> !pwm_on);

  // R6
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_wrap |=> ($stable(act_code) && $stable(act_mask)));

  // R4
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((drive_out & ~$past(act_mask)) == ($past(drive_req) & ~$past(act_mask))));

  // R5
  chop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_on |=> ((drive_out & $past(act_mask)) == '0));

  // R7
  never_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((drive_out & ~$past(drive_req)) == '0));

  logic unused_in;
  assign unused_in = ^{duty_code, pwm_mask};

endmodule

bind hold_pwm_gen hpwm_chk #(
  .STEPS(STEPS), .NUM_BRIDGES(NUM_BRIDGES), .MASK_W(MASK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase),
  .period_wrap(period_wrap), .act_code(act_code), .act_mask(act_mask),
  .pwm_on(pwm_on), .duty_code(duty_code), .pwm_mask(pwm_mask),
  .drive_req(drive_req), .drive_out(drive_out)
);

// File: tb/hold_pwm_gen_bench.sv
module hold_pwm_gen_bench;

  localparam int DIV = 2;
  localparam int STEPS = 100;
  localparam int NB = 6;
  localparam int MW = 8;
  localparam int P = DIV * STEPS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    duty_code = 2'd3;
  logic [MW-1:0] pwm_mask = 8'hFF;
  logic [NB-1:0] drive_req = 6'h3F;
  logic [NB-1:0] drive_out;

  int checks = 0;
  int fails = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  hold_pwm_gen #(.CLK_DIV(DIV), .STEPS(STEPS), .NUM_BRIDGES(NB), .MASK_W(MW)) u_hold_pwm_gen (
    .clk(clk), .rst_n(rst_n), .duty_code(duty_code), .pwm_mask(pwm_mask),
    .drive_req(drive_req), .drive_out(drive_out)
  );

  function automatic int pct_of(input logic [1:0] c);
    case (c)
      2'd0: return 15;
      2'd1: return 30;
      2'd2: return 45;
      default: return 60;
    endcase
  endfunction

  // Reference model: own cycle count from reset release
  int            k = 0;
  logic [1:0]    m_code = '0;
  logic [NB-1:0] m_mask = '0;
  logic [NB-1:0] exp_q[$];
  string         tag_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k = 0; m_code = '0; m_mask = '0;
      exp_q.delete(); tag_q.delete();
    end else begin
      int ph;
      logic on;
      ph = (k / DIV) % STEPS;
      on = (ph * 100) < (pct_of(m_code) * STEPS);
      exp_q.push_back((drive_req & ~m_mask) | (drive_req & m_mask & {NB{on}}));
      tag_q.push_back(cur_tag);
      k = k + 1;
      if (k % P == 0) begin
        m_code = duty_code;
        m_mask = pwm_mask[NB-1:0];
      end
    end
  end

  // Monitor: pops expected items and compares away from the active edge
  int last_rise = -1;
  logic prev0 = 1'b0;
  bit   measure_period = 1'b0;

  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [NB-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (drive_out !== e) begin
        fails++;
        $display("FAIL %s cycle %0d: drive_out=%b expected %b", t, k, drive_out, e);
      end
    end
    if (measure_period && drive_out[0] && !prev0) begin
      if (last_rise >= 0) begin
        checks++;
        if (k - last_rise != P) begin
          fails++;
          $display("FAIL R2: rise spacing=%0d expected %0d", k - last_rise, P);
        end
      end
      last_rise = k;
    end
    prev0 = drive_out[0];
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic to_mid();
    @(negedge clk);
    while (k % P != P / 2) @(negedge clk);
  endtask

  // Driver: new settings at mid-period; they may only act from the next boundary (R6)
  task automatic run_period(input logic [1:0] c, input logic [MW-1:0] m,
                            input logic [NB-1:0] r, input string t);
    to_mid();
    cur_tag = t;
    duty_code = c; pwm_mask = m; drive_req = r;
    cycles(P - 1);
  endtask

  initial begin : main
    fork
      begin
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          checks++;
          if (drive_out !== '0) begin
            fails++;
            $display("FAIL R1: drive_out=%b expected %b during reset", drive_out, 6'b0);
          end
        end
        rst_n = 1'b1;
        cur_tag = "R1";
        cycles(P / 2);
        run_period(2'd0, 8'h2A, 6'h3F, "R3");
        run_period(2'd1, 8'h2A, 6'h3F, "R5");
        run_period(2'd2, 8'h15, 6'h3F, "R3");
        run_period(2'd3, 8'h3F, 6'h3F, "R5");
        run_period(2'd2, 8'hC5, 6'h3F, "R8");
        run_period(2'd1, 8'h15, 6'h2A, "R7");
        // R6: one-cycle glitch in the settings, then revert
        to_mid();
        cur_tag = "R6";
        duty_code = 2'd3; pwm_mask = 8'h3F;
        @(negedge clk);
        duty_code = 2'd1; pwm_mask = 8'h15;
        cycles(P + 10);
        // R4 / R9: random requests every cycle
        cur_tag = "R4";
        for (int i = 0; i < 3 * P; i++) begin
          @(negedge clk);
          drive_req = NB'($urandom);
          if (i == P) cur_tag = "R9";
        end
        // R2: spacing of rising edges of a chopped bridge
        run_period(2'd1, 8'h01, 6'h3F, "R2");
        measure_period = 1'b1;
        cycles(4 * P);
      end
      begin
        cycles(100000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule